// File: doc/BRIEF.md
# Register Scoreboard for Multicycle Functional Units

This block decides, one instruction per cycle, whether an in-order pipeline may send the presented instruction to its functional unit. Each operation class runs on its own unit, and each class has its own result latency and its own initiation interval. The block keeps a countdown timer for every architectural register that an in-flight operation will write, and a second countdown for every unit that is still in its initiation interval.

A presented instruction is granted when none of its sources waits on an outstanding write (read-after-write). Its destination must not be the target of an outstanding write (write-after-write). Its unit must also be ready to accept a new operation. Operands are read at issue, so write-after-read cannot occur and pending reads are not tracked. On a grant the destination timer is loaded with the class latency and the unit timer with the class initiation interval. On a stall nothing is recorded, and the front end presents the same instruction again.

Top module: `reg_scoreboard`

## Requirements
- R1: A presented instruction stalls while either source register (`req_src_a_i` or `req_src_b_i`) has an outstanding write.
- R2: A presented instruction other than a compare stalls while its destination register has an outstanding write.
- R3: Result latencies in cycles are add/subtract 4, multiply 8, divide 36, square root 112, negate 2, absolute value 2, compare 3. An instruction that depends on a result issues exactly that many cycles after its producer issued. A write that completes in the cycle of the check counts as cleared.
- R4: Issuing a register-writing instruction sets `pending_o[dst]` from the next cycle. The bit stays set for latency minus one cycles and then clears by itself.
- R5: Each operation class has its own unit, with initiation intervals add/subtract 3, multiply 4, divide 35, square root 111, negate 1, absolute value 1, compare 2. A second operation on the same unit issues no earlier than that many cycles after the first, even while the first result is still outstanding.
- R6: `issue_o` = request valid and no hazard; `stall_o` = request valid and some hazard; both are low without a request. A stalled or absent request changes no reservation and no unit timer.
- R7: A compare reserves no register, and its destination field is not checked for write-after-write.
- R8: Operation codes on `req_op_i`: 0 add/subtract, 1 multiply, 2 divide, 3 square root, 4 negate, 5 absolute value, 6 compare. Code 7 is reserved: it always stalls and records nothing.
- R9: An active-low reset clears all register reservations and all unit timers.
- R10: Negate and absolute value accept a new operation every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An instruction is presented this cycle |
| req_op_i | input | 3 | Operation class code |
| req_src_a_i | input | REG_W | First source register |
| req_src_b_i | input | REG_W | Second source register |
| req_dst_i | input | REG_W | Destination register |
| issue_o | output | 1 | Instruction granted this cycle |
| stall_o | output | 1 | Instruction held this cycle |
| pending_o | output | NUM_REGS | One bit per register with an outstanding write |

## Verification
On every cycle the assertions check these properties: no grant while a source or a non-compare destination is reserved, a grant always leaves its destination reserved on the next cycle, no reservation appears without a grant or during a stall, a unit stays busy after a start, and the reserved code always stalls. The exact cycle counts are shown only by the bench scenarios. These counts are the release after the full latency, the same-cycle clear, each class's initiation interval, back-to-back negate operations and the reach of a reset into the unit timers. The bench shows them by measuring how long a dependent or competing instruction waits.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int OP_W    = 3;
  localparam int N_OPS   = 7;
  localparam int N_SLOTS = 2 ** OP_W;
  localparam int MAX_LAT = 112;
  localparam int TMR_W   = $clog2(MAX_LAT);

  typedef logic [OP_W-1:0]  op_t;
  typedef logic [TMR_W-1:0] tmr_t;

  localparam op_t OP_ADD  = 3'd0;
  localparam op_t OP_MUL  = 3'd1;
  localparam op_t OP_DIV  = 3'd2;
  localparam op_t OP_SQRT = 3'd3;
  localparam op_t OP_NEG  = 3'd4;
  localparam op_t OP_ABS  = 3'd5;
  localparam op_t OP_CMP  = 3'd6;

  // timer preload = latency - 1
  function automatic tmr_t lat_m1(op_t op);
    case (op)
      OP_ADD:  return TMR_W'(3);
      OP_MUL:  return TMR_W'(7);
      OP_DIV:  return TMR_W'(35);
      OP_SQRT: return TMR_W'(111);
      OP_NEG:  return TMR_W'(1);
      OP_ABS:  return TMR_W'(1);
      OP_CMP:  return TMR_W'(2);
      default: return '0;
    endcase
  endfunction

  // unit preload = initiation interval - 1
  function automatic tmr_t ii_m1(op_t op);
    case (op)
      OP_ADD:  return TMR_W'(2);
      OP_MUL:  return TMR_W'(3);
      OP_DIV:  return TMR_W'(34);
      OP_SQRT: return TMR_W'(110);
      OP_NEG:  return TMR_W'(0);
      OP_ABS:  return TMR_W'(0);
      OP_CMP:  return TMR_W'(1);
      default: return '0;
    endcase
  endfunction

  function automatic logic op_known(op_t op);
    return int'(op) < N_OPS;
  endfunction

  function automatic logic op_writes(op_t op);
    return op_known(op) && op != OP_CMP;
  endfunction
endpackage

// File: rtl/sb_reg_table.sv
module sb_reg_table
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [REG_W-1:0]    set_idx_i,
  input  tmr_t                set_cnt_i,
  output logic [NUM_REGS-1:0] pending_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    tmr_t tmr_q;
    logic hit;
    assign hit = set_i && (set_idx_i == REG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            tmr_q <= '0;
      else if (hit)           tmr_q <= set_cnt_i;
      else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
    end

    assign pending_o[g] = (tmr_q != '0);

    assert_rise_needs_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pending_o[g]) |-> ($past(set_i) && $past(set_idx_i) == REG_W'(g)));
  end

  assert_issue_reserves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && set_cnt_i != '0) |=> pending_o[$past(set_idx_i)]);

endmodule

// File: rtl/sb_unit_tracker.sv
module sb_unit_tracker
  import sb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  op_t                start_op_i,
  output logic [N_SLOTS-1:0] busy_o
);

  for (genvar u = 0; u < N_SLOTS; u++) begin : g_unit
    if (u < N_OPS) begin : g_live
      tmr_t cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   cnt_q <= '0;
        else if (start_i && start_op_i == OP_W'(u))    cnt_q <= ii_m1(start_op_i);
        else if (cnt_q != '0)                          cnt_q <= cnt_q - 1'b1;
      end
      assign busy_o[u] = (cnt_q != '0);
    end else begin : g_none
      assign busy_o[u] = 1'b0;
    end
  end

  assert_ii_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ii_m1(start_op_i) != '0) |=> busy_o[$past(start_op_i)]);

endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                req_valid_i,
  input  op_t                 req_op_i,
  input  logic [REG_W-1:0]    req_src_a_i,
  input  logic [REG_W-1:0]    req_src_b_i,
  input  logic [REG_W-1:0]    req_dst_i,
  input  logic [NUM_REGS-1:0] pending_i,
  input  logic [N_SLOTS-1:0]  unit_busy_i,
  output logic                issue_o,
  output logic                stall_o
);

  logic raw, waw, unit_hit, bad_op, hazard;

  always_comb begin
    raw      = pending_i[req_src_a_i] | pending_i[req_src_b_i];
    waw      = op_writes(req_op_i) & pending_i[req_dst_i];
    unit_hit = unit_busy_i[req_op_i];
    bad_op   = !op_known(req_op_i);
    hazard   = raw | waw | unit_hit | bad_op;
    issue_o  = req_valid_i & ~hazard;
    stall_o  = req_valid_i & hazard;
  end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [OP_W-1:0]     req_op_i,
  input  logic [REG_W-1:0]    req_src_a_i,
  input  logic [REG_W-1:0]    req_src_b_i,
  input  logic [REG_W-1:0]    req_dst_i,
  output logic                issue_o,
  output logic                stall_o,
  output logic [NUM_REGS-1:0] pending_o
);

  logic [N_SLOTS-1:0] unit_busy;
  logic               reserve;

  assign reserve = issue_o && op_writes(req_op_i);

  sb_hazard_check #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) i_check (
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_src_a_i (req_src_a_i),
    .req_src_b_i (req_src_b_i),
    .req_dst_i   (req_dst_i),
    .pending_i   (pending_o),
    .unit_busy_i (unit_busy),
    .issue_o     (issue_o),
    .stall_o     (stall_o)
  );

  sb_reg_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (reserve),
    .set_idx_i (req_dst_i),
    .set_cnt_i (lat_m1(req_op_i)),
    .pending_o (pending_o)
  );

  sb_unit_tracker i_units (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (issue_o),
    .start_op_i (req_op_i),
    .busy_o     (unit_busy)
  );

  assert_no_raw_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (!pending_o[req_src_a_i] && !pending_o[req_src_b_i]));

  assert_no_waw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && req_op_i != OP_CMP) |-> !pending_o[req_dst_i]);

  assert_stall_no_reserve_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_o |=> ((pending_o & ~$past(pending_o)) == '0));

  assert_cmp_no_reserve_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && req_op_i == OP_CMP && !pending_o[req_dst_i]) |=> !pending_o[$past(req_dst_i)]);

  assert_reserved_stalls_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 3'd7) |-> (stall_o && !issue_o));

endmodule

// File: tb/test_reg_scoreboard.sv
module test_reg_scoreboard;
  localparam int NR = 32;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0;
  logic [2:0]    op = '0;
  logic [RW-1:0] sa = '0, sb = '0, dd = '0;
  logic          issue, stall;
  logic [NR-1:0] pend;

  always #2 clk = ~clk;  // 250 MHz

  reg_scoreboard #(.NUM_REGS(NR), .REG_W(RW)) i_reg_scoreboard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_op_i(op),
    .req_src_a_i(sa), .req_src_b_i(sb), .req_dst_i(dd),
    .issue_o(issue), .stall_o(stall), .pending_o(pend));

  typedef struct {
    bit            iss;
    bit            stl;
    logic [NR-1:0] pnd;
    string         tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   errs = 0, checks = 0;
  int   reg_left[NR];
  int   unit_left[8];

  function automatic int m_lat(logic [2:0] o);
    case (o)
      3'd0: return 4;  3'd1: return 8;  3'd2: return 36; 3'd3: return 112;
      3'd4: return 2;  3'd5: return 2;  3'd6: return 3;  default: return 0;
    endcase
  endfunction

  function automatic int m_ii(logic [2:0] o);
    case (o)
      3'd0: return 3;  3'd1: return 4;  3'd2: return 35; 3'd3: return 111;
      3'd4: return 1;  3'd5: return 1;  3'd6: return 2;  default: return 0;
    endcase
  endfunction

  function automatic void model_clear();
    foreach (reg_left[r]) reg_left[r] = 0;
    foreach (unit_left[u]) unit_left[u] = 0;
  endfunction

  function automatic logic [NR-1:0] model_pend();
    logic [NR-1:0] p;
    foreach (reg_left[r]) p[r] = (reg_left[r] > 0);
    return p;
  endfunction

  task automatic check(string tag, string what, logic [NR-1:0] got, logic [NR-1:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      exp_t it;
      @(chk_ev);
      #1;
      it = q.pop_front();
      check(it.tag, "issue_o", NR'(issue), NR'(it.iss));
      check(it.tag, "stall_o", NR'(stall), NR'(it.stl));
      check(it.tag, "pending_o", pend, it.pnd);
    end
  end

  // driver: one cycle of stimulus plus its expectation
  task automatic step(bit v, logic [2:0] o, logic [RW-1:0] a, b, d, string tag, output bit iss);
    exp_t it;
    bit ok;
    @(negedge clk);
    vld = v; op = o; sa = a; sb = b; dd = d;
    ok = (o != 3'd7) && reg_left[a] == 0 && reg_left[b] == 0 &&
         (o == 3'd6 || reg_left[d] == 0) && unit_left[o] == 0;
    iss = v && ok;
    it.iss = iss; it.stl = v && !ok; it.pnd = model_pend(); it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    @(posedge clk);
    foreach (reg_left[r]) if (reg_left[r] > 0) reg_left[r]--;
    foreach (unit_left[u]) if (unit_left[u] > 0) unit_left[u]--;
    if (iss) begin
      if (o != 3'd6) reg_left[d] = m_lat(o) - 1;
      unit_left[o] = m_ii(o) - 1;
    end
  endtask

  task automatic idle(int n);
    bit iss;
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, '0, "R6", iss);
  endtask

  task automatic run_op(logic [2:0] o, logic [RW-1:0] a, b, d, int cap, string tag, int exp_wait);
    bit iss;
    int waited = 0;
    for (int k = 1; k <= cap; k++) begin
      step(1'b1, o, a, b, d, tag, iss);
      if (iss) begin
        waited = k;
        break;
      end
    end
    check(tag, "issue wait", NR'(waited), NR'(exp_wait));
  endtask

  task automatic do_reset();
    @(negedge clk);
    vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_clear();
    check("R9", "pending in reset", pend, '0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    errs++; checks++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    idle(2);

    // RAW on source A, multiply latency
    run_op(3'd1, 5'd1, 5'd2, 5'd5, 5, "R4", 1);
    run_op(3'd4, 5'd5, 5'd0, 5'd6, 20, "R1", 8);
    idle(10);

    // multiply pipelined, RAW on source B
    run_op(3'd1, 5'd0, 5'd0, 5'd11, 5, "R5", 1);
    run_op(3'd1, 5'd0, 5'd0, 5'd12, 10, "R5", 4);
    run_op(3'd4, 5'd0, 5'd12, 5'd13, 20, "R1", 8);
    idle(10);

    // WAW behind divide
    run_op(3'd2, 5'd1, 5'd2, 5'd7, 5, "R2", 1);
    run_op(3'd4, 5'd8, 5'd0, 5'd7, 60, "R2", 36);
    idle(5);

    // divide initiation interval
    run_op(3'd2, 5'd0, 5'd0, 5'd9, 5, "R5", 1);
    run_op(3'd2, 5'd0, 5'd0, 5'd10, 60, "R5", 35);
    idle(40);

    // negate back to back, absolute value RAW with same-cycle clear
    run_op(3'd4, 5'd0, 5'd0, 5'd13, 5, "R10", 1);
    run_op(3'd4, 5'd0, 5'd0, 5'd14, 5, "R10", 1);
    run_op(3'd5, 5'd14, 5'd0, 5'd16, 5, "R3", 2);
    idle(5);

    // compare: no reservation, no WAW on its destination
    run_op(3'd6, 5'd0, 5'd0, 5'd20, 5, "R7", 1);
    run_op(3'd4, 5'd20, 5'd0, 5'd21, 5, "R7", 1);
    run_op(3'd1, 5'd0, 5'd0, 5'd22, 5, "R7", 1);
    run_op(3'd6, 5'd1, 5'd2, 5'd22, 5, "R7", 1);
    run_op(3'd6, 5'd1, 5'd2, 5'd3, 5, "R5", 2);
    idle(10);

    // reserved code
    run_op(3'd7, 5'd0, 5'd0, 5'd23, 4, "R8", 0);
    idle(2);

    // add latency and interval
    run_op(3'd0, 5'd0, 5'd0, 5'd24, 5, "R3", 1);
    run_op(3'd0, 5'd24, 5'd0, 5'd25, 10, "R3", 4);
    run_op(3'd0, 5'd0, 5'd0, 5'd26, 10, "R5", 3);
    idle(10);

    // square root WAW
    run_op(3'd3, 5'd0, 5'd0, 5'd27, 5, "R3", 1);
    run_op(3'd5, 5'd0, 5'd0, 5'd27, 150, "R2", 112);
    idle(5);

    // reset in flight clears registers and unit timers
    run_op(3'd1, 5'd0, 5'd0, 5'd28, 5, "R9", 1);
    run_op(3'd2, 5'd0, 5'd0, 5'd29, 5, "R9", 1);
    do_reset();
    idle(1);
    run_op(3'd2, 5'd28, 5'd0, 5'd28, 5, "R9", 1);
    run_op(3'd1, 5'd29, 5'd0, 5'd30, 5, "R9", 1);
    idle(3);

    #1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule